// File: doc/BRIEF.md
# Integer Add/Subtract Execute Stage

This block is the arithmetic execute stage of a 32-bit load/store processor, limited to the add and subtract instructions. Each cycle it can accept one instruction word together with the two source register values that an upstream register file has already read. It decodes the word into the register-operand or immediate-operand form, forms the sum or difference, and returns a registered result one clock later. The result comes with a destination register index, a write enable, an overflow trap pulse and an illegal-instruction pulse.

The trapping variants check for two's-complement overflow. When one occurs, the stage raises the trap and withholds the register write. The non-trapping variants produce the wrapped value and always write. A destination of register 0 never produces a write, because that register is hard-wired to zero. Any encoding outside the supported set is reported as illegal and causes no write.

Top module: `addsub_exec`

## Requirements
- R1: While `rst_n` is low, and on the first clock after reset, `wr_en`, `ovf_trap`, `illegal`, `wr_idx` and `result` are all zero.
- R2: Outputs reflect the instruction presented with `in_valid` high one clock earlier. After a cycle with `in_valid` low, `wr_en`, `ovf_trap` and `illegal` are all low.
- R3: The register form has opcode `instr[31:26]` = 0, source A in `instr[25:21]`, source B in `instr[20:16]`, destination in `instr[15:11]` and function in `instr[5:0]`. Function 32 gives `result = rs_val + rt_val`. Function 34 gives `result = rs_val - rt_val`. In both cases `wr_idx` is the destination field.
- R4: Function 33 (add) and function 35 (subtract) are the non-trapping register forms. They give the 32-bit wrapped value with `ovf_trap` low and `wr_en` high, even when signed overflow occurs.
- R5: The immediate form uses opcode 8 (trapping) or 9 (non-trapping). It computes `rs_val` plus the sign-extended `instr[15:0]`, and `wr_idx` is taken from `instr[20:16]`.
- R6: A trapping variant (function 32, function 34 or opcode 8) whose true signed result does not fit in 32 bits raises `ovf_trap` for that one output cycle and drives `wr_en` low. `result` still shows the wrapped value.
- R7: Opcode 9 never raises `ovf_trap`, including when its signed sum overflows.
- R8: When the destination index is 0, `wr_en` stays low. `wr_idx` still reports 0.
- R9: Any opcode other than 0, 8 or 9 raises `illegal` and leaves `wr_en` and `ovf_trap` low. Under opcode 0, any function code outside 32..35 does the same.
- R10: The shift-amount field `instr[10:6]` does not affect the register-form result, index or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| wr_en | output | 1 | Register write request |
| wr_idx | output | 5 | Destination register index |
| result | output | 32 | Sum or difference |
| ovf_trap | output | 1 | Signed overflow on a trapping variant |
| illegal | output | 1 | Unsupported encoding |

## Verification
The assertions assume that `in_valid` is never unknown once reset has been released. They also assume that the instruction and operands are stable around each rising edge, so the pulse flags always come from a single decoded word. The stimulus drives every input on the falling edge and holds reset low from time zero. It returns `in_valid` to low between scenarios, so each checked output cycle belongs to exactly one instruction. The operand values are chosen at the sign boundaries, where the overflow rules for add and subtract differ.

// File: rtl/addsub_exec.sv
module addsub_exec #(
  parameter int XLEN = 32,
  parameter int RW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  output logic            wr_en,
  output logic [RW-1:0]   wr_idx,
  output logic [XLEN-1:0] result,
  output logic            ovf_trap,
  output logic            illegal
);
  localparam logic [5:0] OP_REG   = 6'd0;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] OP_ADDIU = 6'd9;
  localparam int         IMMW     = 16;

  logic [5:0]      op, fn;
  logic [RW-1:0]   f_rs, f_rt, f_rd, dest;
  logic            is_reg, is_imm, known, is_sub, traps;
  logic [XLEN-1:0] opnd_b, sum;
  logic            sa, sb, sr, ovf;

  assign op     = instr[31:26];
  assign f_rs   = instr[25:21];
  assign f_rt   = instr[20:16];
  assign f_rd   = instr[15:11];
  assign fn     = instr[5:0];

  assign is_reg = (op == OP_REG) && (fn[5:2] == 4'b1000);
  assign is_imm = (op == OP_ADDI) || (op == OP_ADDIU);
  assign known  = is_reg || is_imm;
  assign is_sub = is_reg && fn[1];
  assign traps  = is_reg ? !fn[0] : (op == OP_ADDI);
  assign dest   = is_reg ? f_rd : f_rt;

  assign opnd_b = is_reg ? rt_val : {{(XLEN-IMMW){instr[IMMW-1]}}, instr[IMMW-1:0]};
  assign sum    = is_sub ? rs_val - opnd_b : rs_val + opnd_b;

  assign sa  = rs_val[XLEN-1];
  assign sb  = opnd_b[XLEN-1];
  assign sr  = sum[XLEN-1];
  assign ovf = traps && (sr != sa) && (is_sub ? (sa != sb) : (sa == sb));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      result   <= '0;
      ovf_trap <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      wr_en    <= in_valid && known && !ovf && (dest != '0);
      ovf_trap <= in_valid && known && ovf;
      illegal  <= in_valid && !known;
      if (in_valid && known) begin
        wr_idx <= dest;
        result <= sum;
      end
    end
  end

  AST_TRAP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap |-> !wr_en);  // R6
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!wr_en && !ovf_trap));  // R9
  AST_NO_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx != '0));  // R8
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!wr_en && !ovf_trap && !illegal));  // R2
  AST_IMM_UNSIGNED_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[31:26] == OP_ADDIU) |=> !ovf_trap);  // R7
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, ovf_trap, illegal}));  // R9
endmodule

// File: tb/addsub_exec_tb.sv
module addsub_exec_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0, rs_val = '0, rt_val = '0;
  logic        wr_en, ovf_trap, illegal;
  logic [4:0]  wr_idx;
  logic [31:0] result;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  addsub_exec u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .rs_val(rs_val), .rt_val(rt_val), .wr_en(wr_en), .wr_idx(wr_idx),
    .result(result), .ovf_trap(ovf_trap), .illegal(illegal));

  function automatic logic [31:0] rfmt(input int rs, input int rt, input int rd, input int sh, input int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
  endfunction

  function automatic logic [31:0] ifmt(input int op, input int rs, input int rt, input logic [15:0] imm);
    return {op[5:0], rs[4:0], rt[4:0], imm};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    instr = w; rs_val = a; rt_val = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_op(input string req, input logic [31:0] w, input logic [31:0] a,
                           input logic [31:0] b, input logic we, input logic [4:0] idx,
                           input logic [31:0] res, input logic trap);
    issue(w, a, b);
    chk(req, "wr_en", {31'd0, wr_en}, {31'd0, we});
    chk(req, "ovf_trap", {31'd0, ovf_trap}, {31'd0, trap});
    chk(req, "illegal", {31'd0, illegal}, 32'd0);
    chk(req, "wr_idx", {27'd0, wr_idx}, {27'd0, idx});
    chk(req, "result", result, res);
  endtask

  task automatic t_reset();
    chk("R1", "wr_en", {31'd0, wr_en}, 32'd0);
    chk("R1", "ovf_trap", {31'd0, ovf_trap}, 32'd0);
    chk("R1", "illegal", {31'd0, illegal}, 32'd0);
    chk("R1", "wr_idx", {27'd0, wr_idx}, 32'd0);
    chk("R1", "result", result, 32'd0);
  endtask

  task automatic t_reg_add_sub();
    expect_op("R3", rfmt(2, 3, 1, 0, 32), 32'd5, 32'd7, 1'b1, 5'd1, 32'd12, 1'b0);
    expect_op("R3", rfmt(2, 3, 4, 0, 34), 32'd10, 32'd3, 1'b1, 5'd4, 32'd7, 1'b0);
    expect_op("R3", rfmt(5, 6, 31, 0, 34), 32'd3, 32'd10, 1'b1, 5'd31, 32'hFFFF_FFF9, 1'b0);
  endtask

  task automatic t_unsigned_wrap();
    expect_op("R4", rfmt(1, 2, 3, 0, 33), 32'h7FFF_FFFF, 32'd1, 1'b1, 5'd3, 32'h8000_0000, 1'b0);
    expect_op("R4", rfmt(1, 2, 7, 0, 35), 32'h8000_0000, 32'd1, 1'b1, 5'd7, 32'h7FFF_FFFF, 1'b0);
  endtask

  task automatic t_immediate();
    expect_op("R5", ifmt(8, 1, 6, 16'hFFFF), 32'd100, 32'hDEAD_BEEF, 1'b1, 5'd6, 32'd99, 1'b0);
    expect_op("R5", ifmt(9, 1, 9, 16'h8000), 32'd0, 32'd0, 1'b1, 5'd9, 32'hFFFF_8000, 1'b0);
  endtask

  task automatic t_overflow();
    expect_op("R6", rfmt(1, 2, 3, 0, 32), 32'h7FFF_FFFF, 32'd1, 1'b0, 5'd3, 32'h8000_0000, 1'b1);
    expect_op("R6", rfmt(1, 2, 3, 0, 32), 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 5'd3, 32'h7FFF_FFFF, 1'b1);
    expect_op("R6", rfmt(1, 2, 3, 0, 34), 32'h8000_0000, 32'd1, 1'b0, 5'd3, 32'h7FFF_FFFF, 1'b1);
    expect_op("R6", rfmt(1, 2, 3, 0, 34), 32'd0, 32'h8000_0000, 1'b0, 5'd3, 32'h8000_0000, 1'b1);
    expect_op("R6", ifmt(8, 1, 4, 16'd1), 32'h7FFF_FFFF, 32'd0, 1'b0, 5'd4, 32'h8000_0000, 1'b1);
    expect_op("R6", rfmt(1, 2, 3, 0, 34), 32'hFFFF_FFFF, 32'h8000_0000, 1'b1, 5'd3, 32'h7FFF_FFFF, 1'b0);
  endtask

  task automatic t_addiu_no_trap();
    expect_op("R7", ifmt(9, 1, 4, 16'd1), 32'h7FFF_FFFF, 32'd0, 1'b1, 5'd4, 32'h8000_0000, 1'b0);
    expect_op("R7", ifmt(9, 1, 4, 16'hFFFF), 32'h8000_0000, 32'd0, 1'b1, 5'd4, 32'h7FFF_FFFF, 1'b0);
  endtask

  task automatic t_zero_dest();
    expect_op("R8", rfmt(1, 2, 0, 0, 32), 32'd1, 32'd2, 1'b0, 5'd0, 32'd3, 1'b0);
    expect_op("R8", ifmt(9, 1, 0, 16'd5), 32'd1, 32'd0, 1'b0, 5'd0, 32'd6, 1'b0);
  endtask

  task automatic t_illegal();
    issue(ifmt(35, 1, 2, 16'd4), 32'd1, 32'd2);
    chk("R9", "illegal opcode", {31'd0, illegal}, 32'd1);
    chk("R9", "wr_en on illegal", {31'd0, wr_en}, 32'd0);
    chk("R9", "trap on illegal", {31'd0, ovf_trap}, 32'd0);
    issue(rfmt(1, 2, 3, 0, 36), 32'h7FFF_FFFF, 32'd1);
    chk("R9", "illegal funct", {31'd0, illegal}, 32'd1);
    chk("R9", "wr_en on bad funct", {31'd0, wr_en}, 32'd0);
    chk("R9", "trap on bad funct", {31'd0, ovf_trap}, 32'd0);
  endtask

  task automatic t_shamt_ignored();
    expect_op("R10", rfmt(2, 3, 8, 31, 32), 32'd40, 32'd2, 1'b1, 5'd8, 32'd42, 1'b0);
    expect_op("R10", rfmt(2, 3, 8, 17, 35), 32'd40, 32'd2, 1'b1, 5'd8, 32'd38, 1'b0);
  endtask

  task automatic t_idle();
    issue(rfmt(1, 2, 3, 0, 32), 32'h7FFF_FFFF, 32'd1);
    chk("R2", "trap after valid", {31'd0, ovf_trap}, 32'd1);
    @(negedge clk);
    chk("R2", "trap after idle", {31'd0, ovf_trap}, 32'd0);
    chk("R2", "wr_en after idle", {31'd0, wr_en}, 32'd0);
    chk("R2", "illegal after idle", {31'd0, illegal}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reg_add_sub();
    t_unsigned_wrap();
    t_immediate();
    t_overflow();
    t_addiu_no_trap();
    t_zero_dest();
    t_illegal();
    t_shamt_ignored();
    t_idle();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule